// File: doc/BRIEF.md
# Serial Clock Pulse Count Qualifier

This block guards the commit step of a serial EEPROM-style slave that takes start, opcode, address and data bits on rising edges of a serial clock. It counts the serial clock rising edges in a frame. The count starts at the edge that carries the start bit and stops when chip select goes low. At that moment it compares the total with the exact length that the decoded instruction needs. A spurious extra edge, for example one caused by noise on the clock line, shifts every later address and data bit by one position. A frame with a wrong count is therefore not allowed to commit.

The block sits next to the instruction decoder. The decoder supplies a one-cycle strobe for each synchronized serial clock rising edge and a strobe marking the start bit. It also supplies the instruction class and, for page writes, the number of words it shifted in. Both values must stay valid while chip select falls. The qualifier answers with a single-cycle permit pulse that the programming controller needs before it may start a write cycle. The address width and the largest page are parameters.

Top module: `mw_clk_qualifier`

## Requirements
- R1: After reset `permit_o` is low and no frame is in progress.
- R2: For class 1 (single-word write) and class 3 (write-all), a permit is given only when the frame held exactly 3 + ADDR_W + 16 clock edges (27 at ADDR_W = 8).
- R3: For class 4 (protect-register write) and class 5 (protect-register clear), a permit is given only when the frame held exactly 3 + ADDR_W edges (11 at ADDR_W = 8).
- R4: For class 2 (page write), a permit is given only when `words_i` is between 1 and MAX_PAGE and the frame held exactly 3 + ADDR_W + 16 × `words_i` edges. A word count of 0 or above MAX_PAGE never gives a permit.
- R5: A frame one edge longer or one edge shorter than required gives no permit.
- R6: `permit_o` is high for exactly one cycle. That cycle follows the first clock in which `cs_i` is sampled low after being high, and `permit_o` is never high at any other time.
- R7: Clock strobes before the start strobe in a frame are not counted. Classes 0, 6 and 7 (no length check) never give a permit.
- R8: The edge count saturates at its maximum value, so a frame far longer than any legal length never wraps around to a legal count.
- R9: The count clears when chip select is low. Strobes that arrive while chip select is low have no effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Synchronized chip select level |
| sclk_rise_i | input | 1 | One-cycle strobe per serial clock rising edge |
| start_i | input | 1 | One-cycle strobe on the edge that carries the start bit (coincides with a sclk_rise_i strobe) |
| class_i | input | 3 | Decoded instruction class, held valid through the chip-select fall |
| words_i | input | PG_W | Page words received, used for class 2 |
| permit_o | output | 1 | One-cycle commit permit after the chip-select fall |

## Verification
The only result is the permit. It is registered at the first clock edge that samples `cs_i` low, so it is valid during the one cycle after the falling edge of `cs_i`. The bench drives all inputs on falling clock edges. When it sees chip select fall, its monitor waits one full clock period, samples the permit there against the value the driver queued, and samples again one period later to confirm that the pulse has ended. Each frame keeps chip select low for several cycles before the next frame starts, so consecutive results never overlap.

// File: rtl/mw_clk_qualifier.sv
`timescale 1ns/1ps
module mw_clk_qualifier #(
  parameter  int ADDR_W   = 8,
  parameter  int MAX_PAGE = 4,
  localparam int PG_W     = $clog2(MAX_PAGE + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_i,
  input  logic            sclk_rise_i,
  input  logic            start_i,
  input  logic [2:0]      class_i,
  input  logic [PG_W-1:0] words_i,
  output logic            permit_o
);
  localparam int LONGEST = 3 + ADDR_W + 16 * MAX_PAGE;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HDR_LEN = CNT_W'(3 + ADDR_W);
  localparam logic [CNT_W-1:0] ONE_LEN = CNT_W'(3 + ADDR_W + 16);

  logic             cs_q, armed_q, permit_q;
  logic [CNT_W-1:0] cnt_q, need;
  logic             checked;

  wire cs_fall = cs_q & ~cs_i;

  always_comb begin
    need    = '0;
    checked = 1'b0;
    case (class_i)
      3'd1, 3'd3: begin need = ONE_LEN; checked = 1'b1; end
      3'd2: if (words_i != '0 && words_i <= PG_W'(MAX_PAGE)) begin
        need    = HDR_LEN + (CNT_W'(words_i) << 4);
        checked = 1'b1;
      end
      3'd4, 3'd5: begin need = HDR_LEN; checked = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      permit_q <= 1'b0;
    end else begin
      cs_q     <= cs_i;
      permit_q <= cs_fall & armed_q & checked & (cnt_q == need);
      if (!cs_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (!armed_q) begin
        if (start_i) begin
          armed_q <= 1'b1;
          cnt_q   <= CNT_W'(1);
        end
      end else if (sclk_rise_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign permit_o = permit_q;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    permit_o |=> !permit_o);
  assert_permit_at_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    permit_o |-> (!$past(cs_i) && $past(cs_i, 2)));
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == '0 || cnt_q >= $past(cnt_q)));
  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> (cnt_q == '0 && !armed_q));
  assert_start_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> cnt_q == '0);
endmodule

// File: tb/mw_clk_qualifier_test.sv
`timescale 1ns/1ps
module mw_clk_qualifier_test;
  localparam int ADDR_W = 8;
  localparam int MAX_PAGE = 4;
  localparam int PG_W = $clog2(MAX_PAGE + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_i = 1'b0, sclk_rise_i = 1'b0, start_i = 1'b0;
  logic [2:0] class_i = '0;
  logic [PG_W-1:0] words_i = '0;
  logic permit_o;

  int tests = 0, fails = 0;
  bit exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  mw_clk_qualifier #(.ADDR_W(ADDR_W), .MAX_PAGE(MAX_PAGE)) uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sclk_rise_i(sclk_rise_i),
    .start_i(start_i), .class_i(class_i), .words_i(words_i), .permit_o(permit_o));

  task automatic check(input string tag, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: permit actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit st);
    @(negedge clk);
    sclk_rise_i = 1'b1;
    start_i = st;
    @(negedge clk);
    sclk_rise_i = 1'b0;
    start_i = 1'b0;
  endtask

  task automatic frame(input int cls, input int wc, input int pre, input int n,
                       input int gap_strobes, input bit exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    class_i = 3'(cls);
    words_i = PG_W'(wc);
    cs_i = 1'b1;
    for (int i = 0; i < pre; i++) pulse(1'b0);
    if (n > 0) pulse(1'b1);
    for (int i = 1; i < n; i++) pulse(1'b0);
    @(negedge clk);
    cs_i = 1'b0;
    for (int i = 0; i < gap_strobes; i++) pulse(1'b0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge cs_i);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check("R6 unexpected frame", permit_o, 1'b0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, permit_o, e);
      end
      @(negedge clk);
      check("R6 pulse ends", permit_o, 1'b0);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset permit low", permit_o, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", permit_o, 1'b0);

    frame(1, 0, 0, 27, 0, 1'b1, "R2 write exact 27");
    frame(1, 0, 0, 28, 0, 1'b0, "R5 write one extra");
    frame(1, 0, 0, 26, 0, 1'b0, "R5 write one short");
    frame(3, 0, 0, 27, 0, 1'b1, "R2 write-all exact 27");
    frame(4, 0, 0, 11, 0, 1'b1, "R3 protect write exact 11");
    frame(5, 0, 0, 11, 0, 1'b1, "R3 protect clear exact 11");
    frame(5, 0, 0, 12, 0, 1'b0, "R5 protect clear one extra");
    frame(2, 1, 0, 27, 0, 1'b1, "R4 page 1 word 27");
    frame(2, 3, 0, 59, 0, 1'b1, "R4 page 3 words 59");
    frame(2, 4, 0, 75, 0, 1'b1, "R4 page 4 words 75");
    frame(2, 4, 0, 74, 0, 1'b0, "R4 page 4 words short");
    frame(2, 0, 0, 11, 0, 1'b0, "R4 page 0 words");
    frame(2, 5, 0, 91, 0, 1'b0, "R4 page above max");
    frame(0, 0, 0, 11, 0, 1'b0, "R7 unchecked class 0");
    frame(6, 0, 0, 27, 0, 1'b0, "R7 unchecked class 6");
    frame(1, 0, 3, 27, 0, 1'b1, "R7 pre-start strobes ignored");
    frame(1, 0, 0, 155, 0, 1'b0, "R8 long frame saturates");
    frame(1, 0, 0, 0, 0, 1'b0, "R7 no start bit");
    frame(1, 0, 0, 27, 5, 1'b1, "R9 write before idle strobes");
    frame(1, 0, 0, 27, 0, 1'b1, "R9 next frame counts from zero");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule